// File: doc/BRIEF.md
# Block and Page Address Translator

This unit turns a 32-bit effective address into a physical address with one lookup. Two translation paths run side by side. The first is a small fully associative array of block entries. Each block entry maps a naturally aligned region whose size is set by a per-entry mask. The second is a two-way set-associative page table cache that maps 4 KB pages. It keeps one least-recently-used bit per set. When both paths match, the block result is returned.

A request is presented with `req_valid`, an effective address and an access type. The unit registers the request and produces its answer combinationally during the following cycle. The answer is a physical address plus hit, miss and block-source flags. Software fills the two structures through two write ports. A block write names the entry it loads. A page write names only the virtual page, and the hardware picks the victim way from the set's LRU bit. Page-table walking and permission faults are left to the surrounding logic. A miss simply reports itself.

Top module: `xlate_unit`

## Requirements
- R1: After reset no block entry and no page entry is valid, so every lookup misses. While no response is due, `rsp_hit`, `rsp_miss`, `rsp_from_block` and `rsp_pa` are all 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. When `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is 1.
- R3: A block entry holds a base (EA bits [31:17]), a target (PA bits [31:17]) and a mask of the same width. A mask bit of 1 removes that EA bit from the compare and passes it through to the PA. For EA bits whose mask bit is 0, the PA takes the target bits. PA bits [16:0] equal EA bits [16:0].
- R4: A block entry has two enable bits, one for fetch accesses (`req_data`=0) and one for data accesses (`req_data`=1). An entry matches only when the enable for the request's access type is 1.
- R5: When several block entries match, the entry with the lowest index supplies the translation.
- R6: When a block entry and a page entry both match, the block translation is returned and `rsp_from_block` is 1. `rsp_from_block` is 1 only on block hits.
- R7: On a page hit the PA is {page number, EA[11:0]}. EA[16:12] selects one of 32 sets, and EA[31:17] is the tag.
- R8: Both ways of a set hold independent translations, and both can hit.
- R9: A page write goes into the way named by its set's LRU bit and then points that bit at the other way. A lookup that hits a page way points the bit at the way that did not hit. If a page write and a lookup update touch the same set in the same cycle, the write wins.
- R10: On a miss `rsp_pa` is 0 and no page entry or LRU bit changes.
- R11: A page write with `tw_valid`=0 leaves an invalid entry in the victim way, and that entry never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | Access type: 1 data, 0 fetch |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_pa | output | 32 | Physical address, 0 on miss |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Neither path matched |
| rsp_from_block | output | 1 | Result came from a block entry |
| bw_en | input | 1 | Block entry write strobe |
| bw_idx | input | 2 | Block entry index |
| bw_base | input | 15 | Block base, EA bits [31:17] |
| bw_target | input | 15 | Block target, PA bits [31:17] |
| bw_mask | input | 15 | Pass-through mask |
| bw_en_fetch | input | 1 | Entry enabled for fetches |
| bw_en_data | input | 1 | Entry enabled for data accesses |
| tw_en | input | 1 | Page refill write strobe |
| tw_vpn | input | 20 | Virtual page number, EA bits [31:12] |
| tw_ppn | input | 20 | Physical page number |
| tw_valid | input | 1 | Valid bit written with the entry |

## Verification
Each response is due in the cycle after its request edge. The bench drives a request at a falling edge and samples all five result outputs at the next falling edge, when the registered request has settled through the combinational compare. Writes take one edge to land. LRU updates land on the edge after the response cycle, so each lookup and write task idles for one more cycle before the next operation. This keeps the reference model's update order the same as the hardware's.

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int EA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int TLB_SETS  = 32,
  parameter int BLK_N     = 4,
  parameter int BLK_LO    = 17,
  localparam int SET_W    = $clog2(TLB_SETS),
  localparam int VPN_W    = EA_W - PAGE_BITS,
  localparam int TAG_W    = VPN_W - SET_W,
  localparam int BW       = EA_W - BLK_LO,
  localparam int IDX_W    = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [EA_W-1:0]  req_ea,
  input  logic             req_data,
  output logic             rsp_valid,
  output logic [EA_W-1:0]  rsp_pa,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_from_block,
  input  logic             bw_en,
  input  logic [IDX_W-1:0] bw_idx,
  input  logic [BW-1:0]    bw_base,
  input  logic [BW-1:0]    bw_target,
  input  logic [BW-1:0]    bw_mask,
  input  logic             bw_en_fetch,
  input  logic             bw_en_data,
  input  logic             tw_en,
  input  logic [VPN_W-1:0] tw_vpn,
  input  logic [VPN_W-1:0] tw_ppn,
  input  logic             tw_valid
);

  logic            q_v, q_d;
  logic [EA_W-1:0] q_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) q_v <= 1'b0;
    else        q_v <= req_valid;
    if (req_valid) begin
      q_ea <= req_ea;
      q_d  <= req_data;
    end
  end

  logic [BW-1:0]    b_base [BLK_N];
  logic [BW-1:0]    b_tgt  [BLK_N];
  logic [BW-1:0]    b_mask [BLK_N];
  logic [BLK_N-1:0] b_ef, b_ed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_ef <= '0;
      b_ed <= '0;
    end else if (bw_en) begin
      b_base[bw_idx] <= bw_base;
      b_tgt[bw_idx]  <= bw_target;
      b_mask[bw_idx] <= bw_mask;
      b_ef[bw_idx]   <= bw_en_fetch;
      b_ed[bw_idx]   <= bw_en_data;
    end
  end

  wire [BW-1:0] q_hi = q_ea[EA_W-1:BLK_LO];
  logic [BLK_N-1:0] b_hit;
  logic [BW-1:0]    b_out [BLK_N];

  for (genvar i = 0; i < BLK_N; i++) begin : g_blk
    assign b_hit[i] = (q_d ? b_ed[i] : b_ef[i]) &&
                      (((q_hi ^ b_base[i]) & ~b_mask[i]) == '0);
    assign b_out[i] = (b_tgt[i] & ~b_mask[i]) | (q_hi & b_mask[i]);
  end

  logic [BW-1:0] b_sel;
  always_comb begin
    b_sel = '0;
    for (int i = BLK_N - 1; i >= 0; i--)
      if (b_hit[i]) b_sel = b_out[i];
  end
  wire b_any = |b_hit;

  logic [TLB_SETS-1:0] t_v   [2];
  logic [TAG_W-1:0]    t_tag [2][TLB_SETS];
  logic [VPN_W-1:0]    t_ppn [2][TLB_SETS];
  logic [TLB_SETS-1:0] lru;

  wire [SET_W-1:0] q_set = q_ea[PAGE_BITS+SET_W-1:PAGE_BITS];
  wire [TAG_W-1:0] q_tag = q_ea[EA_W-1:PAGE_BITS+SET_W];
  logic [1:0] w_hit;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign w_hit[w] = t_v[w][q_set] && (t_tag[w][q_set] == q_tag);
  end

  wire             t_hit   = |w_hit;
  wire             hit_way = ~w_hit[0];
  wire [VPN_W-1:0] hit_ppn = t_ppn[hit_way][q_set];

  wire [SET_W-1:0] tw_set = tw_vpn[SET_W-1:0];
  wire [TAG_W-1:0] tw_tag = tw_vpn[VPN_W-1:SET_W];
  wire             victim = lru[tw_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v[0] <= '0;
      t_v[1] <= '0;
      lru    <= '0;
    end else begin
      if (q_v && t_hit) lru[q_set] <= ~hit_way;
      if (tw_en) begin
        t_v[victim][tw_set]   <= tw_valid;
        t_tag[victim][tw_set] <= tw_tag;
        t_ppn[victim][tw_set] <= tw_ppn;
        lru[tw_set]           <= ~victim;
      end
    end
  end

  assign rsp_valid      = q_v;
  assign rsp_hit        = q_v && (b_any || t_hit);
  assign rsp_miss       = q_v && !b_any && !t_hit;
  assign rsp_from_block = q_v && b_any;
  assign rsp_pa = !q_v  ? '0 :
                  b_any ? {b_sel, q_ea[BLK_LO-1:0]} :
                  t_hit ? {hit_ppn, q_ea[PAGE_BITS-1:0]} : '0;

endmodule

module xlate_unit_chk #(
  parameter int EA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [EA_W-1:0] req_ea,
  input logic            rsp_valid,
  input logic [EA_W-1:0] rsp_pa,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_from_block
);
  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));
  // R2
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_from_block && rsp_pa == '0));
  // R10
  miss_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0));
  // R6
  block_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_from_block |-> (rsp_hit && !rsp_miss));
  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_pa[PAGE_BITS-1:0] == $past(req_ea[PAGE_BITS-1:0])));
endmodule

bind xlate_unit xlate_unit_chk #(.EA_W(EA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_from_block(rsp_from_block));

// File: tb/test_xlate_unit.sv
`timescale 1ns/1ps
module test_xlate_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_data = 0;
  logic [31:0] req_ea = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_from_block;
  logic [31:0] rsp_pa;
  logic bw_en = 0, bw_en_fetch = 0, bw_en_data = 0;
  logic [1:0] bw_idx = 0;
  logic [14:0] bw_base = 0, bw_target = 0, bw_mask = 0;
  logic tw_en = 0, tw_valid = 0;
  logic [19:0] tw_vpn = 0, tw_ppn = 0;

  always #2.5 clk = ~clk;

  xlate_unit i_xlate_unit (.*);

  int total = 0, bad = 0;

  logic [14:0] m_base [4], m_tgt [4], m_mask [4];
  logic [3:0]  m_ef = 0, m_ed = 0;
  logic        m_tv  [2][32];
  logic [14:0] m_tag [2][32];
  logic [19:0] m_ppn [2][32];
  logic [31:0] m_lru = 0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic blk_write(int idx, logic [14:0] base, logic [14:0] tgt, logic [14:0] mk,
                           logic ef, logic ed);
    @(negedge clk);
    bw_en = 1; bw_idx = idx[1:0]; bw_base = base; bw_target = tgt; bw_mask = mk;
    bw_en_fetch = ef; bw_en_data = ed;
    @(negedge clk);
    bw_en = 0;
    m_base[idx] = base; m_tgt[idx] = tgt; m_mask[idx] = mk; m_ef[idx] = ef; m_ed[idx] = ed;
  endtask

  task automatic tlb_write(logic [19:0] vpn, logic [19:0] ppn, logic v);
    int s, w;
    @(negedge clk);
    tw_en = 1; tw_vpn = vpn; tw_ppn = ppn; tw_valid = v;
    @(negedge clk);
    tw_en = 0;
    s = int'(vpn[4:0]);
    w = int'(m_lru[s]);
    m_tv[w][s] = v; m_tag[w][s] = vpn[19:5]; m_ppn[w][s] = ppn;
    m_lru[s] = ~m_lru[s];
  endtask

  task automatic lookup(string req, logic [31:0] ea, logic d);
    logic hit = 0, blk = 0;
    logic [31:0] pa = 0;
    int s = int'(ea[16:12]);
    int way = -1;
    for (int i = 3; i >= 0; i--)
      if ((d ? m_ed[i] : m_ef[i]) && (((ea[31:17] ^ m_base[i]) & ~m_mask[i]) == 0)) begin
        blk = 1;
        pa = {(m_tgt[i] & ~m_mask[i]) | (ea[31:17] & m_mask[i]), ea[16:0]};
      end
    for (int w = 1; w >= 0; w--)
      if (m_tv[w][s] && m_tag[w][s] == ea[31:17]) way = w;
    hit = blk || (way >= 0);
    if (!blk && way >= 0) pa = {m_ppn[way][s], ea[11:0]};
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk("R2", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, hit});
    chk(req, "rsp_miss", {31'd0, rsp_miss}, {31'd0, !hit});
    chk(req, "rsp_from_block", {31'd0, rsp_from_block}, {31'd0, blk});
    chk(req, "rsp_pa", rsp_pa, pa);
    if (way >= 0) m_lru[s] = (way == 0);
    @(negedge clk);
    chk("R2", "rsp_valid drop", {31'd0, rsp_valid}, 32'd0);
  endtask

  function automatic logic [14:0] tg(int s, int k);
    return (k == 0) ? 15'h0040 + 15'(s) : 15'h0400 + 15'(s);
  endfunction

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r = 32'h1234_5679;
    for (int w = 0; w < 2; w++) for (int s = 0; s < 32; s++) m_tv[w][s] = 0;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_tgt[i] = 0; m_mask[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "idle valid", {31'd0, rsp_valid}, 0);
    chk("R1", "idle pa", rsp_pa, 0);
    chk("R1", "idle hit", {31'd0, rsp_hit}, 0);
    lookup("R1", 32'h0000_0000, 0);
    lookup("R1", 32'h8000_1234, 1);
    lookup("R1", 32'hFFFF_FFFF, 0);

    // R7 R8 fill both ways of every set
    for (int s = 0; s < 32; s++) begin
      tlb_write({tg(s, 0), 5'(s)}, 20'h30000 + 20'(s * 2), 1);
      tlb_write({tg(s, 1), 5'(s)}, 20'h30000 + 20'(s * 2 + 1), 1);
    end
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 2; k++)
        lookup((k == 0) ? "R7" : "R8", {tg(s, k), 5'(s), 12'(s * 97 + k * 5)}, k[0]);

    // R9 hit on way 0 makes way 1 the victim
    lookup("R9", {tg(3, 0), 5'd3, 12'h010}, 0);
    tlb_write({15'h1111, 5'd3}, 20'hABCDE, 1);
    lookup("R9", {tg(3, 1), 5'd3, 12'h020}, 0);
    lookup("R9", {tg(3, 0), 5'd3, 12'h030}, 0);
    lookup("R9", {15'h1111, 5'd3, 12'h040}, 1);

    // R10 a miss leaves the LRU bit alone
    lookup("R10", {tg(5, 1), 5'd5, 12'h001}, 0);
    lookup("R10", {15'h2222, 5'd5, 12'h002}, 0);
    tlb_write({15'h3333, 5'd5}, 20'h0F0F0, 1);
    lookup("R10", {tg(5, 1), 5'd5, 12'h003}, 0);
    lookup("R10", {tg(5, 0), 5'd5, 12'h004}, 0);
    lookup("R10", {15'h3333, 5'd5, 12'h005}, 0);

    // R11 invalid refill never hits
    tlb_write({15'h4444, 5'd7}, 20'h12345, 0);
    lookup("R11", {15'h4444, 5'd7, 12'h777}, 1);

    // R3 R4 block entries, data only on entry 2
    blk_write(2, 15'h4000, 15'h0800, 15'h07FF, 0, 1);
    lookup("R3", 32'h8000_0000, 1);
    lookup("R3", 32'h8010_0ABC, 1);
    lookup("R3", 32'h8FFF_FFFF, 1);
    lookup("R3", 32'h9000_0000, 1);
    lookup("R4", 32'h8010_0000, 0);
    // R5 smaller overlapping region at lower index
    blk_write(1, 15'h4000, 15'h1000, 15'h0000, 1, 1);
    lookup("R5", 32'h8000_1234, 1);
    lookup("R5", 32'h8001_FFFF, 0);
    lookup("R5", 32'h8002_0000, 1);
    blk_write(3, 15'h4000, 15'h2800, 15'h07FF, 1, 0);
    lookup("R4", 32'h8010_0000, 0);
    lookup("R4", 32'h8010_0000, 1);
    // R6 block overrides page
    tlb_write({15'h4000, 5'd9}, 20'hDEAD0, 1);
    lookup("R6", 32'h8000_9444, 1);
    blk_write(1, 15'h4000, 15'h1000, 15'h0000, 0, 0);
    blk_write(2, 15'h4000, 15'h0800, 15'h07FF, 0, 0);
    lookup("R6", 32'h8000_9444, 1);
    lookup("R4", 32'h8000_9444, 0);

    // mixed sweep
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ea;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      case (r[1:0])
        2'd0: ea = {tg(int'(r[8:4]), 0), r[8:4], r[20:9]};
        2'd1: ea = {tg(int'(r[8:4]), 1), r[8:4], r[20:9]};
        2'd2: ea = {4'h8, r[29:2]};
        default: ea = r;
      endcase
      lookup("R7", ea, r[31]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule